// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

This block produces a system reset from two causes: a supply sample that sits under a selectable trip level, and a pushbutton that is held low long enough to count as a deliberate press. The supply arrives as a digitized value in millivolts. A tolerance-select input picks one of two trip levels. The button arrives as a raw, asynchronous active-low level.

Both causes feed one state machine with three states. `ST_ASSERT` holds reset while either cause is present; after the asynchronous reset input, the machine starts here. `ST_HOLD` keeps reset asserted while a timer counts out the hold interval. `ST_RELEASED` is the only state in which reset is deasserted. The transitions are `ASSERT->HOLD` when no cause is present, `HOLD->ASSERT` when a cause returns (the timer is cleared), `HOLD->RELEASED` when the timer completes, and `RELEASED->ASSERT` when any cause appears. All intervals come from a clock-frequency parameter and millisecond parameters, so a simulation can use short cycle counts.

Top module: `supv_reset_gen`

## Requirements
- R1: `rst_out` is always the exact logical inverse of `rst_out_n`.
- R2: With `tol_sel` low the trip level is `TRIP_LO_MV` (default 4620 mV). With `tol_sel` high it is `TRIP_HI_MV` (default 4370 mV). A sample equal to or above the selected level counts as good.
- R3: A supply sample below the selected trip level makes `rst_out` high one clock later.
- R4: After the supply becomes good again, reset stays asserted for at least `HOLD_CYC` (= CLK_HZ/1000*HOLD_MS) cycles. It releases no later than `HOLD_CYC`+2 cycles after recovery.
- R5: `btn_n` is passed through a two-flop synchronizer. A low level held for `PRESS_CYC` (= CLK_HZ/1000*PRESS_MS) synchronized cycles asserts reset. A shorter low pulse has no effect on the outputs.
- R6: After a qualified press, reset stays asserted while the button is held and for at least `HOLD_CYC` cycles after it returns high.
- R7: While `rst_n` is low, the outputs are in the asserted state (`rst_out`=1, `rst_out_n`=0) and all counters are cleared.
- R8: If a cause reappears during the hold interval, the interval starts again from zero once the cause clears.
- R9: Changing `tol_sel` during a hold, without making the supply low, does not clear or extend the hold that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| vsup_mv | input | VW | Supply sample in millivolts |
| tol_sel | input | 1 | Trip-level select (0: TRIP_LO_MV, 1: TRIP_HI_MV) |
| btn_n | input | 1 | Raw active-low pushbutton level |
| rst_out | output | 1 | Active-high reset |
| rst_out_n | output | 1 | Active-low reset |

## Verification
The assertions check four things on every cycle: the output complement, that an under-threshold sample forces reset one clock later, that no release follows fewer than the hold-interval cycles of assertion, and that a button held low past qualification plus synchronizer latency always shows reset. The bench scenarios cover the rest: the upper bound on release time, rejection of short button pulses, the restart of the hold when a cause returns mid-interval, and that a `tol_sel` change does not disturb a running hold. Each of these is a sequence of events, not a property of a single cycle.

// File: rtl/sup_pkg.sv
package sup_pkg;
    typedef enum logic [1:0] {
        ST_ASSERT   = 2'd0,
        ST_HOLD     = 2'd1,
        ST_RELEASED = 2'd2
    } sup_state_e;

    function automatic int ms_to_cyc(input int clk_hz, input int ms);
        return (clk_hz / 1000) * ms;
    endfunction
endpackage

// File: rtl/sup_sync2.sv
module sup_sync2 #(
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic meta_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q_sync <= RST_VAL;
        end else begin
            meta_q <= d_async;
            q_sync <= meta_q;
        end
    end
endmodule

// File: rtl/sup_press_qual.sv
module sup_press_qual #(
    parameter int PRESS_CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic btn_s,
    output logic pressed
);
    localparam int CW = $clog2(PRESS_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(PRESS_CYC - 1);

    logic [CW-1:0] low_cnt;

    // Count consecutive low cycles; any high level restarts the count.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
            pressed <= 1'b0;
        end else if (btn_s) begin
            low_cnt <= '0;
            pressed <= 1'b0;
        end else if (low_cnt == LAST) begin
            pressed <= 1'b1;
        end else begin
            low_cnt <= low_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sup_trip_cmp.sv
module sup_trip_cmp #(
    parameter int VW         = 13,
    parameter int TRIP_LO_MV = 4620,
    parameter int TRIP_HI_MV = 4370
) (
    input  logic [VW-1:0] vsup_mv,
    input  logic          tol_sel,
    output logic          supply_low
);
    localparam logic [VW-1:0] LVL_LO = VW'(TRIP_LO_MV);
    localparam logic [VW-1:0] LVL_HI = VW'(TRIP_HI_MV);

    logic [VW-1:0] level;

    always_comb begin
        level      = tol_sel ? LVL_HI : LVL_LO;
        supply_low = (vsup_mv < level);
    end
endmodule

// File: rtl/sup_hold_timer.sv
module sup_hold_timer #(
    parameter int HOLD_CYC = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(HOLD_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

    logic [CW-1:0] cnt;

    assign done = (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (run && !done) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
    import sup_pkg::*;
#(
    parameter int CLK_HZ     = 50_000_000,
    parameter int PRESS_MS   = 20,
    parameter int HOLD_MS    = 250,
    parameter int VW         = 13,
    parameter int TRIP_LO_MV = 4620,
    parameter int TRIP_HI_MV = 4370
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] vsup_mv,
    input  logic          tol_sel,
    input  logic          btn_n,
    output logic          rst_out,
    output logic          rst_out_n
);
    localparam int PRESS_CYC = ms_to_cyc(CLK_HZ, PRESS_MS);
    localparam int HOLD_CYC  = ms_to_cyc(CLK_HZ, HOLD_MS);

    sup_state_e state_q, state_d;
    logic       btn_s;
    logic       pressed;
    logic       supply_low;
    logic       cause;
    logic       hold_done;

    sup_sync2 #(.RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (btn_n),
        .q_sync  (btn_s)
    );

    sup_press_qual #(.PRESS_CYC(PRESS_CYC)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .btn_s   (btn_s),
        .pressed (pressed)
    );

    sup_trip_cmp #(
        .VW         (VW),
        .TRIP_LO_MV (TRIP_LO_MV),
        .TRIP_HI_MV (TRIP_HI_MV)
    ) u_cmp (
        .vsup_mv    (vsup_mv),
        .tol_sel    (tol_sel),
        .supply_low (supply_low)
    );

    sup_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (state_q != ST_HOLD),
        .run   (state_q == ST_HOLD),
        .done  (hold_done)
    );

    assign cause = supply_low | pressed;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ASSERT:   if (!cause) state_d = ST_HOLD;
            ST_HOLD:     if (cause) state_d = ST_ASSERT;
                         else if (hold_done) state_d = ST_RELEASED;
            ST_RELEASED: if (cause) state_d = ST_ASSERT;
            default:     state_d = ST_ASSERT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_ASSERT;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        rst_out   = (state_q != ST_RELEASED);
        rst_out_n = (state_q == ST_RELEASED);
    end
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int PRESS_MS   = 20,
    parameter int HOLD_MS    = 250,
    parameter int VW         = 13,
    parameter int TRIP_LO_MV = 4620,
    parameter int TRIP_HI_MV = 4370
) (
    input logic          clk,
    input logic          rst_n,
    input logic [VW-1:0] vsup_mv,
    input logic          tol_sel,
    input logic          btn_n,
    input logic          rst_out,
    input logic          rst_out_n
);
    localparam int PRESS_CYC = (CLK_HZ / 1000) * PRESS_MS;
    localparam int HOLD_CYC  = (CLK_HZ / 1000) * HOLD_MS;

    int hi_run;
    int low_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run  <= 0;
            low_run <= 0;
        end else begin
            hi_run  <= !rst_out ? 0 : (hi_run < HOLD_CYC + 8 ? hi_run + 1 : hi_run);
            low_run <= btn_n ? 0 : (low_run < PRESS_CYC + 8 ? low_run + 1 : low_run);
        end
    end

    // R1
    complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_out == !rst_out_n);

    // R3
    undervolt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(vsup_mv) < (tol_sel ? TRIP_HI_MV : TRIP_LO_MV)) |=> rst_out);

    // R4
    hold_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out) |-> (hi_run >= HOLD_CYC));

    // R5
    press_assert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_run >= PRESS_CYC + 4) |-> rst_out);
endmodule

bind supv_reset_gen supv_reset_chk #(
    .CLK_HZ     (CLK_HZ),
    .PRESS_MS   (PRESS_MS),
    .HOLD_MS    (HOLD_MS),
    .VW         (VW),
    .TRIP_LO_MV (TRIP_LO_MV),
    .TRIP_HI_MV (TRIP_HI_MV)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .vsup_mv   (vsup_mv),
    .tol_sel   (tol_sel),
    .btn_n     (btn_n),
    .rst_out   (rst_out),
    .rst_out_n (rst_out_n)
);

// File: tb/supv_reset_gen_bench.sv
module supv_reset_gen_bench;
    localparam int CLK_HZ = 1000;
    localparam int PRESS  = 20;
    localparam int HOLD   = 250;
    localparam int VW     = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [VW-1:0] vsup_mv = VW'(5000);
    logic          tol_sel = 1'b0;
    logic          btn_n = 1'b1;
    logic          rst_out, rst_out_n;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    supv_reset_gen #(
        .CLK_HZ(CLK_HZ), .PRESS_MS(PRESS), .HOLD_MS(HOLD), .VW(VW),
        .TRIP_LO_MV(4620), .TRIP_HI_MV(4370)
    ) u_supv_reset_gen (
        .clk(clk), .rst_n(rst_n), .vsup_mv(vsup_mv), .tol_sel(tol_sel),
        .btn_n(btn_n), .rst_out(rst_out), .rst_out_n(rst_out_n)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rst_out actual=%b expected=%b", req, act, exp);
        end
        if (rst_out !== ~rst_out_n) begin
            n_fail++;
            $display("FAIL R1: rst_out=%b rst_out_n=%b expected inverse", rst_out, rst_out_n);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Checks a hold: asserted after 240 cycles, released by 260.
    task automatic chk_hold(input string req);
        cyc(240);
        chk(req, rst_out, 1'b1);
        cyc(20);
        chk(req, rst_out, 1'b0);
    endtask

    task automatic t_power_on();
        cyc(3);
        chk("R7", rst_out, 1'b1);
        chk("R7", rst_out_n, 1'b0);
        rst_n = 1'b1;
        chk_hold("R4");
    endtask

    task automatic t_supply_dip();
        vsup_mv = VW'(4500);
        cyc(1);
        chk("R3", rst_out, 1'b1);
        cyc(100);
        chk("R3", rst_out, 1'b1);
        vsup_mv = VW'(5000);
        chk_hold("R4");
    endtask

    task automatic t_tol_select();
        vsup_mv = VW'(4620);
        cyc(10);
        chk("R2", rst_out, 1'b0);
        tol_sel = 1'b1;
        vsup_mv = VW'(4500);
        cyc(20);
        chk("R2", rst_out, 1'b0);
        vsup_mv = VW'(4369);
        cyc(1);
        chk("R2", rst_out, 1'b1);
        vsup_mv = VW'(5000);
        tol_sel = 1'b0;
        chk_hold("R2");
    endtask

    task automatic t_short_press();
        btn_n = 1'b0;
        cyc(15);
        btn_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            cyc(1);
            chk("R5", rst_out, 1'b0);
        end
    endtask

    task automatic t_long_press();
        btn_n = 1'b0;
        cyc(30);
        chk("R5", rst_out, 1'b1);
        cyc(300);
        chk("R6", rst_out, 1'b1);
        btn_n = 1'b1;
        cyc(2);
        chk_hold("R6");
    endtask

    task automatic t_restart();
        vsup_mv = VW'(4000);
        cyc(5);
        vsup_mv = VW'(5000);
        cyc(100);
        vsup_mv = VW'(4000);
        cyc(5);
        vsup_mv = VW'(5000);
        chk_hold("R8");
    endtask

    task automatic t_tol_during_hold();
        vsup_mv = VW'(4000);
        cyc(5);
        vsup_mv = VW'(5000);
        cyc(100);
        tol_sel = 1'b1;
        cyc(140);
        chk("R9", rst_out, 1'b1);
        cyc(20);
        chk("R9", rst_out, 1'b0);
        tol_sel = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        t_power_on();
        t_supply_dip();
        t_tol_select();
        t_short_press();
        t_long_press();
        t_restart();
        t_tol_during_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule